// File: doc/BRIEF.md
# Multicast Port-Mask Flush Engine

This block runs in the background. It sweeps an address lookup table once and removes a set of egress ports from every multicast address entry. The sweep can be limited to entries of one VLAN. A single strobe launches the sweep. The engine then reads each table slot in ascending order and evaluates it. It writes the slot back only when the port removal changes it. An entry that loses its last port is converted into a free slot. It is not kept with an empty mask.

The table is external to the block. The engine reaches it through a read port with one cycle of read latency and a separate write port. The port count and the table depth are parameters.

Each entry is `66 + NUM_PORTS` bits wide, with these fields:

| Field | Bits |
|---|---|
| Type | 61:60 |
| VLAN tag | 59:48 |
| MAC address | 47:0 (group bit is bit 40) |
| Super flag | bit 65 |
| Port mask | bit 66 upward, one bit per port |

Top module: `mcast_flush_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rdEn` and `wrEn` are all low.
- R2: A `start` pulse while idle captures `portMask`, `vlanId` and `anyVlan`. Input changes after that capture have no effect on the sweep in progress. A `start` pulse while `busy` is high is ignored.
- R3: The sweep visits every index from 0 to DEPTH-1 in ascending order and spends two cycles on each index: one read cycle and one evaluate cycle. `done` pulses high for exactly one cycle, 2*DEPTH cycles after the capturing edge, and `busy` is low in that cycle. Read and write are never active in the same cycle.
- R4: Only entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN address) can be modified. Types 0 and 2 are left untouched.
- R5: When `anyVlan` is low, an entry whose bits 59:48 differ from the captured `vlanId` is left untouched. When `anyVlan` is high, every VLAN tag qualifies.
- R6: An entry is modified only if its group bit (bit 40) is 1 and its super bit (bit 65) is 0.
- R7: An entry whose MAC field (bits 47:0) is all ones is never modified.
- R8: The port mask occupies bits 66 upward. When the entry mask and the requested mask have no bit in common, the entry is left unchanged. This includes the case of a zero requested mask.
- R9: A qualifying entry has the requested bits cleared from its mask. A write happens only when the entry changes. The write goes to the index just read, one cycle after the read request.
- R10: When the cleared mask becomes zero, the entry is written with type 0 and a zero mask. All other bits of the entry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a sweep when idle |
| portMask | input | NUM_PORTS | Ports to remove |
| vlanId | input | 12 | VLAN tag to restrict the sweep to |
| anyVlan | input | 1 | High to process all VLAN tags |
| rdEn | output | 1 | Table read request |
| rdAddr | output | IDX_W | Table read index |
| rdData | input | ENTRY_W | Entry returned one cycle after `rdEn` |
| wrEn | output | 1 | Table write strobe |
| wrAddr | output | IDX_W | Table write index |
| wrData | output | ENTRY_W | Entry to write |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the engine with NUM_PORTS = 4 and DEPTH = 16. A four-bit mask is narrow enough to write out partial clears, full clears and disjoint masks by hand. Sixteen slots keep a whole sweep short enough to check every slot, the exact end-of-sweep cycle and the total number of writes, both in a mixed-table sweep and in a sweep where `start` is pulsed again midway. The single-entry vectors isolate each exemption (type, VLAN tag, group bit, super bit, broadcast MAC, disjoint mask) so that each one decides the outcome on its own.

// File: rtl/mcflush_pkg.sv
package mcflush_pkg;
  localparam int TYPE_LO   = 60;
  localparam int VID_LO    = 48;
  localparam int VID_W     = 12;
  localparam int MAC_W     = 48;
  localparam int GROUP_BIT = 40;
  localparam int SUPER_BIT = 65;
  localparam int MASK_LO   = 66;

  localparam logic [1:0] TYPE_FREE  = 2'd0;
  localparam logic [1:0] TYPE_ADDR  = 2'd1;
  localparam logic [1:0] TYPE_VADDR = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2
  } flushState_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
  } flushStrobes_t;
endpackage

// File: rtl/mcflush_ctrl.sv
module mcflush_ctrl
  import mcflush_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             entryChanged,
  output flushStrobes_t    strobes,
  output logic             rdEn,
  output logic [IDX_W-1:0] rdAddr,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrAddr,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  flushState_t state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          idx   <= '0;
          state <= ST_READ;
        end
        ST_READ: state <= ST_EVAL;
        ST_EVAL: begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture  = (state == ST_IDLE) && start;
    strobes.evaluate = (state == ST_EVAL);
    rdEn   = (state == ST_READ);
    rdAddr = idx;
    wrEn   = strobes.evaluate && entryChanged;
    wrAddr = idx;
    busy   = (state != ST_IDLE);
  end

  // R9
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($past(rdEn) && wrAddr == $past(rdAddr)));

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !wrEn));
endmodule

// File: rtl/mcflush_dp.sv
module mcflush_dp
  import mcflush_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ENTRY_W   = 70
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flushStrobes_t        strobes,
  input  logic [NUM_PORTS-1:0] reqMaskIn,
  input  logic [VID_W-1:0]     reqVidIn,
  input  logic                 anyVlanIn,
  input  logic [ENTRY_W-1:0]   rdData,
  output logic                 entryChanged,
  output logic [ENTRY_W-1:0]   wrData
);
  logic [NUM_PORTS-1:0] reqMaskQ;
  logic [VID_W-1:0]     reqVidQ;
  logic                 anyVlanQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqMaskQ <= '0;
      reqVidQ  <= '0;
      anyVlanQ <= 1'b0;
    end else if (strobes.capture) begin
      reqMaskQ <= reqMaskIn;
      reqVidQ  <= reqVidIn;
      anyVlanQ <= anyVlanIn;
    end
  end

  logic [1:0]           entType;
  logic [NUM_PORTS-1:0] curMask;
  logic [NUM_PORTS-1:0] newMask;
  logic isAddrType, vlanOk, isGroup, isSuper, isBcast, overlaps;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign curMask[p] = rdData[MASK_LO + p];
    assign newMask[p] = curMask[p] & ~reqMaskQ[p];
  end

  always_comb begin
    entType    = rdData[TYPE_LO +: 2];
    isAddrType = (entType == TYPE_ADDR) || (entType == TYPE_VADDR);
    vlanOk     = anyVlanQ || (rdData[VID_LO +: VID_W] == reqVidQ);
    isGroup    = rdData[GROUP_BIT];
    isSuper    = rdData[SUPER_BIT];
    isBcast    = &rdData[MAC_W-1:0];
    overlaps   = |(curMask & reqMaskQ);
    entryChanged = isAddrType && vlanOk && isGroup && !isSuper && !isBcast && overlaps;

    wrData = rdData;
    wrData[MASK_LO +: NUM_PORTS] = newMask;
    if (newMask == '0) wrData[TYPE_LO +: 2] = TYPE_FREE;
  end

  // R9
  mask_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evaluate && entryChanged) |->
      (((wrData[MASK_LO +: NUM_PORTS] & ~curMask) == '0) &&
       (wrData[MASK_LO +: NUM_PORTS] != curMask)));

  // R2
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.capture) |-> ($stable(reqMaskQ) && $stable(reqVidQ) && $stable(anyVlanQ)));
endmodule

// File: rtl/mcast_flush_engine.sv
module mcast_flush_engine
  import mcflush_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 16,
  localparam int ENTRY_W  = MASK_LO + NUM_PORTS,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NUM_PORTS-1:0] portMask,
  input  logic [VID_W-1:0]     vlanId,
  input  logic                 anyVlan,
  output logic                 rdEn,
  output logic [IDX_W-1:0]     rdAddr,
  input  logic [ENTRY_W-1:0]   rdData,
  output logic                 wrEn,
  output logic [IDX_W-1:0]     wrAddr,
  output logic [ENTRY_W-1:0]   wrData,
  output logic                 busy,
  output logic                 done
);
  flushStrobes_t strobes;
  logic entryChanged;

  mcflush_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .entryChanged(entryChanged),
    .strobes(strobes), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .busy(busy), .done(done)
  );

  mcflush_dp #(.NUM_PORTS(NUM_PORTS), .ENTRY_W(ENTRY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqMaskIn(portMask),
    .reqVidIn(vlanId), .anyVlanIn(anyVlan), .rdData(rdData),
    .entryChanged(entryChanged), .wrData(wrData)
  );

  // R7
  bcast_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(&wrData[MAC_W-1:0]));

  // R10
  free_on_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[MASK_LO +: NUM_PORTS] == '0) |-> (wrData[TYPE_LO +: 2] == TYPE_FREE));
endmodule

// File: tb/mcast_flush_engine_tb.sv
module mcast_flush_engine_tb;
  localparam int NP = 4;
  localparam int DEPTH = 16;
  localparam int EW = 66 + NP;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NP-1:0] portMask = '0;
  logic [11:0] vlanId = '0;
  logic anyVlan = 1'b0;
  logic rdEn, wrEn, busy, done;
  logic [IW-1:0] rdAddr, wrAddr;
  logic [EW-1:0] rdData, wrData;

  always #2.5 clk = ~clk;

  mcast_flush_engine #(.NUM_PORTS(NP), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .portMask(portMask),
    .vlanId(vlanId), .anyVlan(anyVlan), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .done(done)
  );

  logic [EW-1:0] mem [DEPTH];
  int wrCount = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    if (rdEn) rdData <= mem[rdAddr];
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      wrCount <= wrCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] typ; logic [11:0] vid; logic mc; logic sup; logic bc;
    logic [3:0] mask; logic [3:0] req; logic [11:0] rvid; logic anyv;
    logic [1:0] etyp; logic [3:0] emask; logic ew;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd1, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1011, 4'b0010, 12'd0, 1'b1, 2'd1, 4'b1001, 1'b1}, // R9
    '{2'd3, 12'd5, 1'b1, 1'b0, 1'b0, 4'b0110, 4'b0110, 12'd5, 1'b0, 2'd0, 4'b0000, 1'b1}, // R10
    '{2'd3, 12'd5, 1'b1, 1'b0, 1'b0, 4'b0110, 4'b0110, 12'd6, 1'b0, 2'd3, 4'b0110, 1'b0}, // R5
    '{2'd3, 12'd7, 1'b1, 1'b0, 1'b0, 4'b1111, 4'b0001, 12'd2, 1'b1, 2'd3, 4'b1110, 1'b1}, // R5
    '{2'd1, 12'd0, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b1111, 12'd0, 1'b1, 2'd1, 4'b1111, 1'b0}, // R6
    '{2'd1, 12'd0, 1'b1, 1'b0, 1'b1, 4'b1111, 4'b1111, 12'd0, 1'b1, 2'd1, 4'b1111, 1'b0}, // R7
    '{2'd1, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1100, 4'b0011, 12'd0, 1'b1, 2'd1, 4'b1100, 1'b0}, // R8
    '{2'd2, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 4'b1111, 12'd0, 1'b1, 2'd2, 4'b1111, 1'b0}, // R4
    '{2'd0, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 4'b1111, 12'd0, 1'b1, 2'd0, 4'b1111, 1'b0}, // R4
    '{2'd1, 12'd0, 1'b0, 1'b0, 1'b0, 4'b1111, 4'b1111, 12'd0, 1'b1, 2'd1, 4'b1111, 1'b0}, // R6
    '{2'd1, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1111, 4'b0000, 12'd0, 1'b1, 2'd1, 4'b1111, 1'b0}, // R8
    '{2'd1, 12'd9, 1'b1, 1'b0, 1'b0, 4'b1000, 4'b1000, 12'd9, 1'b0, 2'd0, 4'b0000, 1'b1}  // R10
  };

  function automatic logic [EW-1:0] mk(input logic [1:0] typ, input logic [11:0] vid,
      input logic mc, input logic sup, input logic bc, input logic [3:0] mask);
    logic [EW-1:0] e;
    e = '0;
    e[63:62] = 2'b10;
    e[64] = 1'b1;
    e[61:60] = typ;
    e[59:48] = vid;
    e[47:0] = bc ? {48{1'b1}} : (mc ? 48'h01005e0000ab : 48'h00aabbccddee);
    e[65] = sup;
    e[69:66] = mask;
    return e;
  endfunction

  function automatic logic [EW-1:0] refModel(input logic [EW-1:0] e, input logic [3:0] req,
      input logic [11:0] rvid, input logic anyv);
    logic [EW-1:0] r;
    r = e;
    if ((e[61:60] == 2'd1 || e[61:60] == 2'd3) && (anyv || e[59:48] == rvid) &&
        e[40] && !e[65] && !(&e[47:0]) && ((e[69:66] & req) != 0)) begin
      r[69:66] = e[69:66] & ~req;
      if (r[69:66] == 0) r[61:60] = 2'd0;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runFlush(input logic [3:0] req, input logic [11:0] rvid, input logic anyv,
      output int took);
    @(negedge clk);
    wrCount = 0;
    portMask = req; vlanId = rvid; anyVlan = anyv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    took = 0;
    while (!done && took < 1000) begin
      @(negedge clk);
      took = took + 1;
    end
  endtask

  initial begin
    int took;
    int expWr;
    logic [EW-1:0] expMem [DEPTH];
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", EW'(busy), EW'(0));
    check("R1 done", EW'(done), EW'(0));
    check("R1 rdEn", EW'(rdEn), EW'(0));
    check("R1 wrEn", EW'(wrEn), EW'(0));
    rstN = 1'b1;

    for (int v = 0; v < 12; v++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      mem[5] = mk(VECS[v].typ, VECS[v].vid, VECS[v].mc, VECS[v].sup, VECS[v].bc, VECS[v].mask);
      runFlush(VECS[v].req, VECS[v].rvid, VECS[v].anyv, took);
      check($sformatf("R4-R10 vector %0d entry", v), mem[5],
            mk(VECS[v].etyp, VECS[v].vid, VECS[v].mc, VECS[v].sup, VECS[v].bc, VECS[v].emask));
      check($sformatf("R9 vector %0d writes", v), EW'(wrCount), EW'(VECS[v].ew));
    end

    // R3: full mixed table, all indices, exact sweep length
    expWr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = mk(2'(i % 4), 12'(i % 2), (i % 3) != 0, i == 7, i == 13, 4'(i));
      expMem[i] = refModel(mem[i], 4'b0101, 12'd0, 1'b1);
      if (expMem[i] != mem[i]) expWr = expWr + 1;
    end
    runFlush(4'b0101, 12'd0, 1'b1, took);
    check("R3 sweep length", EW'(took), EW'(2 * DEPTH));
    check("R3 busy low at done", EW'(busy), EW'(0));
    @(negedge clk);
    check("R3 done one cycle", EW'(done), EW'(0));
    for (int i = 0; i < DEPTH; i++) check($sformatf("R3 slot %0d", i), mem[i], expMem[i]);
    check("R9 total writes", EW'(wrCount), EW'(expWr));

    // R2: restart while busy ignored, input changes after capture ignored
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd1, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1111);
    @(negedge clk);
    wrCount = 0;
    portMask = 4'b0001; vlanId = 12'd0; anyVlan = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    portMask = 4'b1110;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    took = 0;
    while (!done && took < 1000) begin
      @(negedge clk);
      took = took + 1;
    end
    check("R2 sweep not restarted", EW'(took + 6), EW'(2 * DEPTH));
    for (int i = 0; i < DEPTH; i++)
      check($sformatf("R2 slot %0d", i), mem[i], mk(2'd1, 12'd0, 1'b1, 1'b0, 1'b0, 4'b1110));
    repeat (2) @(negedge clk);
    check("R2 idle after sweep", EW'(busy), EW'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule